// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It drives the address, the 16-bit data bus and the chip, output and write enable strobes. A client hands it one request at a time over a valid/ready handshake. The request is a word program, a sector erase, a whole-array erase or a product-identity read. The block turns the request into the unlock write cycles the flash expects. Every strobe is timed by a clock-cycle count that is derived from nanosecond parameters, so the bus timing holds at any clock frequency.

After a program or erase command, the sequencer reads the flash repeatedly and watches the status bits in the returned data until the operation has finished. It uses one of two methods: the polarity of data bit 7, or a bit 6 that stops toggling. If no completion is seen within a configurable number of reads, it gives up with a timeout status. Before a program command it reads the target word. If the new value would need any bit to go from 0 to 1, it refuses the request without writing anything, because programming can only clear bits.

Each accepted request ends in exactly one response pulse, which carries a status code and a data word.

Top module: `nvm_cmd_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and `fl_ce_n`, `fl_oe_n` and `fl_we_n` are all 1. Every accepted request produces exactly one single-cycle `rsp_valid` pulse.
- R2: In each write cycle, `fl_ce_n` and `fl_we_n` are low together for at least WP_NS (200 ns). `fl_oe_n` stays high whenever `fl_we_n` is low.
- R3: Between two write pulses, `fl_we_n` stays high for at least WPH_NS (200 ns).
- R4: A program request (`req_op`=0) first reads the target word. It then writes, in order: 00AA at 5555, 0055 at 2AAA, 00A0 at 5555, and the request data at the request address.
- R5: An erase writes six cycles: 00AA@5555, 0055@2AAA, 0080@5555, 00AA@5555, 0055@2AAA, then a last cycle. For a sector erase (`req_op`=1) the last cycle is 0030 at the request address. For a whole-array erase (`req_op`=2) it is 0010 at 5555.
- R6: If the stored word has a 0 in any bit where the program data has a 1, the block issues no write cycle. It responds with status 2 and returns the stored word as data.
- R7: With `req_toggle`=0 (data polling), a program completes on the first read whose bit 7 equals bit 7 of the written data. An erase completes on the first read whose bit 7 is 1. The response has status 0 and carries that read word.
- R8: With `req_toggle`=1, completion is declared when bit 6 is equal on two consecutive status reads. Between reads, `fl_oe_n` is high for at least OEH_NS (150 ns).
- R9: If TIMEOUT_POLLS status reads pass without completion, the block responds with status 1 and returns to idle.
- R10: An identity request (`req_op`=3) writes 00AA@5555, 0055@2AAA and 0090@5555. It then reads address 0 and address 1, and writes 00F0 at address 0. The response data is {low byte of read 1, low byte of read 0}.
- R11: While a request is in progress, `req_ready` stays 0 and a held `req_valid` is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_op | input | 2 | 0 program, 1 sector erase, 2 whole-array erase, 3 identity read |
| req_addr | input | AW | Word address (program target or sector address) |
| req_data | input | 16 | Program data |
| req_toggle | input | 1 | 0 data polling on bit 7, 1 toggle detection on bit 6 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 0 ok, 1 timeout, 2 refused (bit would rise) |
| rsp_data | output | 16 | Last word read, or identity bytes |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 16 | Write data to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 16 | Read data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The hardest cases to reach are the completion corners. One is a flash that never finishes, which must exhaust the poll budget. Another is the point in toggle detection where the bit stops changing.

The flash stub on the bench is given a busy-read count for each request. For the timeout case, that count is set so large that the poll budget runs out. The bench builds the sequencer with a small TIMEOUT_POLLS so that this happens in a short run.

The refused-program case is set up by first programming a word. A second request then tries to raise one of its bits. The stub's write monitor confirms that no bus write follows.

// File: rtl/nvm_seq_pkg.sv
`timescale 1ns/1ps
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_ID   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_BITRISE = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREREAD,
        S_CMD,
        S_POLL,
        S_RESP
    } fsm_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_SETUP,
        E_LOW,
        E_HIGH
    } eng_e;

endpackage

// File: rtl/nvm_bus_cycle.sv
`timescale 1ns/1ps
// One asynchronous bus cycle (read or write), timed in clock cycles.
module nvm_bus_cycle
    import nvm_seq_pkg::*;
#(
    parameter int AW      = 17,
    parameter int WP_CYC  = 25,
    parameter int WPH_CYC = 25,
    parameter int RD_CYC  = 15,
    parameter int OEH_CYC = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic          done,
    output logic [15:0]   rdata,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);

    localparam int MAX_A   = (WP_CYC > RD_CYC) ? WP_CYC : RD_CYC;
    localparam int MAX_B   = (WPH_CYC > OEH_CYC) ? WPH_CYC : OEH_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        eng_e          st;
        logic          wr;
        logic [AW-1:0] addr;
        logic [15:0]   wdata;
        logic [CNT_W-1:0] cnt;
        logic [15:0]   rdata;
    } eng_t;

    eng_t q, d;
    logic [CNT_W-1:0] low_last, high_last;

    always_comb begin
        low_last  = q.wr ? CNT_W'(WP_CYC - 1)  : CNT_W'(RD_CYC - 1);
        high_last = q.wr ? CNT_W'(WPH_CYC - 1) : CNT_W'(OEH_CYC - 1);
        d    = q;
        done = 1'b0;
        case (q.st)
            E_IDLE: begin
                if (start) begin
                    d.st    = E_SETUP;
                    d.wr    = wr;
                    d.addr  = addr;
                    d.wdata = wdata;
                    d.cnt   = '0;
                end
            end
            E_SETUP: d.st = E_LOW;
            E_LOW: begin
                if (q.cnt == low_last) begin
                    d.st  = E_HIGH;
                    d.cnt = '0;
                    if (!q.wr) d.rdata = fl_dq_in;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            E_HIGH: begin
                if (q.cnt == high_last) begin
                    d.st = E_IDLE;
                    done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = E_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: E_IDLE, wr: 1'b0, addr: '0, wdata: '0, cnt: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.rdata;
    assign fl_addr   = q.addr;
    assign fl_dq_out = q.wdata;
    assign fl_dq_oe  = (q.st != E_IDLE) && q.wr;
    assign fl_ce_n   = (q.st != E_LOW);
    assign fl_we_n   = !((q.st == E_LOW) && q.wr);
    assign fl_oe_n   = !((q.st == E_LOW) && !q.wr);

    // Low-time counter used only by the pulse width check.
    logic [CNT_W:0] we_low_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        we_low_q <= '0;
        else if (!fl_we_n) we_low_q <= we_low_q + 1'b1;
        else               we_low_q <= '0;
    end

    // R2
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> we_low_q >= (CNT_W+1)'(WP_CYC));
    // R2
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_oe_n && !fl_ce_n);
    // R1
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> q.st == E_IDLE);

endmodule

// File: rtl/nvm_done_detect.sv
`timescale 1ns/1ps
// Completion decision from one status read and the previous one.
module nvm_done_detect (
    input  logic       toggle_mode,
    input  logic       is_erase,
    input  logic       exp_b7,
    input  logic [7:6] rd_bits,
    input  logic       prev_vld,
    input  logic       prev_b6,
    output logic       complete
);

    always_comb begin
        if (toggle_mode) begin
            complete = prev_vld && (rd_bits[6] == prev_b6);
        end else if (is_erase) begin
            complete = rd_bits[7];
        end else begin
            complete = (rd_bits[7] == exp_b7);
        end
        // R8
        toggle_prev_chk: assert (!(toggle_mode && complete) || prev_vld);
    end

endmodule

// File: rtl/nvm_cmd_sequencer.sv
`timescale 1ns/1ps
module nvm_cmd_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int AW            = 17,
    parameter int CLK_NS        = 8,
    parameter int WP_NS         = 200,
    parameter int WPH_NS        = 200,
    parameter int RD_NS         = 120,
    parameter int OEH_NS        = 150,
    parameter int TIMEOUT_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_data,
    input  logic          req_toggle,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [15:0]   rsp_data,
    output logic [AW-1:0] fl_addr,
    output logic [15:0]   fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [15:0]   fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);

    localparam int WP_CYC  = (WP_NS  + CLK_NS - 1) / CLK_NS;
    localparam int WPH_CYC = (WPH_NS + CLK_NS - 1) / CLK_NS;
    localparam int RD_CYC  = (RD_NS  + CLK_NS - 1) / CLK_NS;
    localparam int OEH_CYC = (OEH_NS + CLK_NS - 1) / CLK_NS;
    localparam int PCW     = $clog2(TIMEOUT_POLLS + 1);
    localparam logic [AW-1:0] A_5555 = AW'(17'h05555);
    localparam logic [AW-1:0] A_2AAA = AW'(17'h02AAA);

    typedef struct packed {
        logic          rd;
        logic [AW-1:0] a;
        logic [15:0]   w;
    } cmd_t;

    typedef struct packed {
        fsm_e          st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [15:0]   data;
        logic          tog;
        logic [2:0]    step;
        logic          launched;
        logic [PCW-1:0] poll_cnt;
        logic          prev_vld;
        logic          prev_b6;
        status_e       status;
        logic [15:0]   rdata;
    } seq_t;

    function automatic cmd_t cmd_word(op_e op, logic [2:0] step,
                                      logic [AW-1:0] a, logic [15:0] w);
        cmd_t c;
        c.rd = 1'b0;
        c.a  = A_5555;
        c.w  = 16'h00AA;
        case (step)
            3'd0: ;
            3'd1: begin c.a = A_2AAA; c.w = 16'h0055; end
            3'd2: c.w = (op == OP_PROG) ? 16'h00A0 : (op == OP_ID) ? 16'h0090 : 16'h0080;
            3'd3: begin
                if (op == OP_PROG)    begin c.a = a;  c.w = w; end
                else if (op == OP_ID) begin c.a = '0; c.rd = 1'b1; end
            end
            3'd4: begin
                if (op == OP_ID) begin c.a = AW'(1); c.rd = 1'b1; end
                else begin c.a = A_2AAA; c.w = 16'h0055; end
            end
            default: begin
                if (op == OP_ID)        begin c.a = '0; c.w = 16'h00F0; end
                else if (op == OP_SECT) begin c.a = a;  c.w = 16'h0030; end
                else                    c.w = 16'h0010;
            end
        endcase
        return c;
    endfunction

    seq_t q, d;
    cmd_t cw;
    logic          eng_start, eng_wr, eng_done, complete;
    logic [AW-1:0] eng_addr;
    logic [15:0]   eng_wdata, eng_rdata;
    logic [2:0]    last_step;

    nvm_bus_cycle #(
        .AW(AW), .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC),
        .RD_CYC(RD_CYC), .OEH_CYC(OEH_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .wr(eng_wr), .addr(eng_addr), .wdata(eng_wdata),
        .done(eng_done), .rdata(eng_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    nvm_done_detect u_det (
        .toggle_mode(q.tog),
        .is_erase(q.op != OP_PROG),
        .exp_b7(q.data[7]),
        .rd_bits(eng_rdata[7:6]),
        .prev_vld(q.prev_vld),
        .prev_b6(q.prev_b6),
        .complete(complete)
    );

    always_comb begin
        d         = q;
        cw        = cmd_word(q.op, q.step, q.addr, q.data);
        last_step = (q.op == OP_PROG) ? 3'd3 : 3'd5;
        eng_start = 1'b0;
        eng_wr    = 1'b0;
        eng_addr  = q.addr;
        eng_wdata = q.data;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.op       = op_e'(req_op);
                    d.addr     = req_addr;
                    d.data     = req_data;
                    d.tog      = req_toggle;
                    d.step     = '0;
                    d.launched = 1'b0;
                    d.poll_cnt = '0;
                    d.prev_vld = 1'b0;
                    d.prev_b6  = 1'b0;
                    d.status   = ST_OK;
                    d.rdata    = '0;
                    d.st       = (op_e'(req_op) == OP_PROG) ? S_PREREAD : S_CMD;
                end
            end
            S_PREREAD: begin
                eng_start  = !q.launched;
                d.launched = 1'b1;
                if (eng_done) begin
                    d.launched = 1'b0;
                    d.rdata    = eng_rdata;
                    if (|(~eng_rdata & q.data)) begin
                        d.status = ST_BITRISE;
                        d.st     = S_RESP;
                    end else begin
                        d.st = S_CMD;
                    end
                end
            end
            S_CMD: begin
                eng_start  = !q.launched;
                eng_wr     = !cw.rd;
                eng_addr   = cw.a;
                eng_wdata  = cw.w;
                d.launched = 1'b1;
                if (eng_done) begin
                    d.launched = 1'b0;
                    if (cw.rd && q.step == 3'd3) d.rdata[7:0]  = eng_rdata[7:0];
                    if (cw.rd && q.step == 3'd4) d.rdata[15:8] = eng_rdata[7:0];
                    if (q.step == last_step) begin
                        d.st = (q.op == OP_ID) ? S_RESP : S_POLL;
                    end else begin
                        d.step = q.step + 1'b1;
                    end
                end
            end
            S_POLL: begin
                eng_start  = !q.launched;
                d.launched = 1'b1;
                if (eng_done) begin
                    d.launched = 1'b0;
                    d.poll_cnt = q.poll_cnt + 1'b1;
                    d.rdata    = eng_rdata;
                    d.prev_vld = 1'b1;
                    d.prev_b6  = eng_rdata[6];
                    if (complete) begin
                        d.status = ST_OK;
                        d.st     = S_RESP;
                    end else if (q.poll_cnt + 1'b1 == PCW'(TIMEOUT_POLLS)) begin
                        d.status = ST_TIMEOUT;
                        d.st     = S_RESP;
                    end
                end
            end
            S_RESP:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, op: OP_PROG, addr: '0, data: '0, tog: 1'b0,
                   step: '0, launched: 1'b0, poll_cnt: '0, prev_vld: 1'b0,
                   prev_b6: 1'b0, status: ST_OK, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign rsp_valid  = (q.st == S_RESP);
    assign rsp_status = q.status;
    assign rsp_data   = q.rdata;

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    // R1
    single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);
    // R9
    timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status == ST_TIMEOUT |-> q.poll_cnt == PCW'(TIMEOUT_POLLS));
    // R6
    bitrise_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_status == ST_BITRISE |-> q.op == OP_PROG && q.step == 3'd0);

endmodule

// File: tb/sim_nvm_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_nvm_cmd_sequencer;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic          req_toggle = 1'b0;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [15:0]   rsp_data;
    logic [AW-1:0] fl_addr;
    logic [15:0]   fl_dq_out;
    logic          fl_dq_oe;
    logic [15:0]   fl_dq_in;
    logic          fl_ce_n, fl_oe_n, fl_we_n;

    always #4 clk = ~clk;

    nvm_cmd_sequencer #(.AW(AW), .TIMEOUT_POLLS(16)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // ---------------- scoreboard queues ----------------
    typedef struct { logic [AW-1:0] a; logic [15:0] w; string tag; } wr_item_t;
    typedef struct { logic [1:0] st; logic [15:0] dat; logic [15:0] msk; string tag; } rsp_item_t;
    wr_item_t  wr_q[$];
    rsp_item_t rsp_q[$];
    int rsp_seen = 0;

    task automatic push_w(input logic [AW-1:0] a, input logic [15:0] w, input string tag);
        wr_item_t it;
        it.a = a; it.w = w; it.tag = tag;
        wr_q.push_back(it);
    endtask

    // ---------------- flash stub ----------------
    logic [15:0] mem [16];
    int  busy = 0, knob = 0, reads = 0;
    bit  tog = 0, erasing = 0, idmode = 0;
    logic [15:0] pdata = '0, rd_word = '0;
    logic [7:0]  w1 = '0, w2 = '0;
    logic [AW-1:0] wa = '0;
    realtime t_wf = 0, t_wr = -1000, t_or = -1000;
    int viol_wp = 0, viol_gap = 0, viol_oe = 0, viol_oeh = 0;

    assign fl_dq_in = rd_word;

    initial for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;

    always @(negedge fl_we_n) if (rst_n) begin
        wa   = fl_addr;
        t_wf = $realtime;
        if (t_wf - t_wr < 200.0) viol_gap++;
        if (!fl_oe_n) viol_oe++;
    end

    always @(posedge fl_we_n) if (rst_n) begin
        logic [15:0] dv;
        wr_item_t it;
        dv   = fl_dq_out;
        t_wr = $realtime;
        if (t_wr - t_wf < 200.0) viol_wp++;
        if (!fl_oe_n || !fl_dq_oe) viol_oe++;
        if (wr_q.size() == 0) begin
            chk(1'b0, "R6 unexpected write", {15'd0, wa}, 32'hFFFFFFFF);
        end else begin
            it = wr_q.pop_front();
            chk(wa == it.a && dv == it.w, it.tag, {dv, wa[15:0]}, {it.w, it.a[15:0]});
        end
        if (w1 == 8'hA0 && w2 == 8'h55) begin
            mem[wa[3:0]] = mem[wa[3:0]] & dv;
            pdata = dv; busy = knob; erasing = 0;
        end else if ((dv[7:0] == 8'h30 || dv[7:0] == 8'h10) && w1 == 8'h55 && w2 == 8'hAA) begin
            for (int i = 0; i < 16; i++) mem[i] = 16'hFFFF;
            busy = knob; erasing = 1;
        end else if (dv[7:0] == 8'h90 && w1 == 8'h55) begin
            idmode = 1;
        end else if (dv[7:0] == 8'hF0) begin
            idmode = 0;
        end
        w2 = w1;
        w1 = dv[7:0];
    end

    always @(negedge fl_oe_n) if (rst_n) begin
        if ($realtime - t_or < 150.0) viol_oeh++;
        reads++;
        if (idmode) begin
            rd_word = fl_addr[0] ? 16'h0082 : 16'h001F;
        end else if (busy > 0) begin
            rd_word = {8'h00, (erasing ? 1'b0 : ~pdata[7]), tog, 6'b0};
            tog = ~tog;
            busy--;
        end else begin
            rd_word = mem[fl_addr[3:0]];
        end
    end

    always @(posedge fl_oe_n) if (rst_n) t_or = $realtime;

    // ---------------- response monitor ----------------
    always @(negedge clk) if (rst_n && rsp_valid) begin
        rsp_item_t it;
        if (rsp_q.size() == 0) begin
            chk(1'b0, "R1 unexpected response", {14'd0, rsp_status, rsp_data}, 32'h0);
        end else begin
            it = rsp_q.pop_front();
            chk(rsp_status == it.st && ((rsp_data ^ it.dat) & it.msk) == 16'h0,
                it.tag, {14'd0, rsp_status, rsp_data}, {14'd0, it.st, it.dat});
        end
        rsp_seen++;
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] w,
                         input bit tg, input int bz, input logic [1:0] est,
                         input logic [15:0] edat, input logic [15:0] emsk, input string tag);
        rsp_item_t it;
        it.st = est; it.dat = edat; it.msk = emsk; it.tag = tag;
        rsp_q.push_back(it);
        knob = bz;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = w; req_toggle = tg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int n);
        while (rsp_seen < n) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic unlock(input string tag);
        push_w(17'h05555, 16'h00AA, tag);
        push_w(17'h02AAA, 16'h0055, tag);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // ---------------- tests ----------------
    initial begin
        int r0;
        bit held_ok;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !rsp_valid && fl_ce_n && fl_oe_n && fl_we_n, "R1 reset state",
            {27'd0, req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n}, 32'h17);

        // R4 + R7: program, data polling, 5 busy reads
        unlock("R4 program unlock");
        push_w(17'h05555, 16'h00A0, "R4 program opcode");
        push_w(17'h00003, 16'h1234, "R4 program data");
        r0 = reads;
        issue(2'd0, 17'h00003, 16'h1234, 1'b0, 5, 2'd0, 16'h1234, 16'hFFFF, "R7 program data poll");
        wait_rsp(1);
        chk(reads - r0 == 7, "R7 program poll read count", reads - r0, 7);
        chk(wr_q.size() == 0, "R4 all program writes seen", wr_q.size(), 0);

        // R6: raise bit 0 of a programmed word, no writes expected
        issue(2'd0, 17'h00003, 16'h1235, 1'b0, 5, 2'd2, 16'h1234, 16'hFFFF, "R6 bit-rise refused");
        wait_rsp(2);
        chk(mem[3] == 16'h1234, "R6 stored word untouched", mem[3], 16'h1234);

        // R8: program with toggle detection
        unlock("R4 program unlock");
        push_w(17'h05555, 16'h00A0, "R4 program opcode");
        push_w(17'h00003, 16'h0204, "R4 program data");
        issue(2'd0, 17'h00003, 16'h0204, 1'b1, 6, 2'd0, 16'h0204, 16'hFFFF, "R8 program toggle");
        wait_rsp(3);

        // R5 + R7: sector erase, data polling
        unlock("R5 sector unlock");
        push_w(17'h05555, 16'h0080, "R5 sector setup");
        unlock("R5 sector unlock 2");
        push_w(17'h05000, 16'h0030, "R5 sector confirm");
        r0 = reads;
        issue(2'd1, 17'h05000, 16'h0000, 1'b0, 4, 2'd0, 16'hFFFF, 16'hFFFF, "R7 sector erase poll");
        wait_rsp(4);
        chk(reads - r0 == 5, "R7 erase poll read count", reads - r0, 5);

        // R5 + R8: whole-array erase, toggle detection
        unlock("R5 chip unlock");
        push_w(17'h05555, 16'h0080, "R5 chip setup");
        unlock("R5 chip unlock 2");
        push_w(17'h05555, 16'h0010, "R5 chip confirm");
        issue(2'd2, 17'h00000, 16'h0000, 1'b1, 3, 2'd0, 16'hFFFF, 16'hFFFF, "R8 chip erase toggle");
        wait_rsp(5);

        // R9: flash never finishes
        unlock("R4 program unlock");
        push_w(17'h05555, 16'h00A0, "R4 program opcode");
        push_w(17'h00005, 16'h00F0, "R4 program data");
        r0 = reads;
        issue(2'd0, 17'h00005, 16'h00F0, 1'b0, 100000, 2'd1, 16'h0000, 16'h0000, "R9 timeout status");
        wait_rsp(6);
        chk(reads - r0 == 17, "R9 poll budget used", reads - r0, 17);
        chk(req_ready, "R9 back to idle", req_ready, 1);
        busy = 0;

        // R10 + R11: identity read while a second request is held
        unlock("R10 id unlock");
        push_w(17'h05555, 16'h0090, "R10 id entry");
        push_w(17'h00000, 16'h00F0, "R10 id exit");
        issue(2'd3, 17'h00000, 16'h0000, 1'b0, 0, 2'd0, 16'h821F, 16'hFFFF, "R10 identity data");
        req_valid = 1'b1; req_op = 2'd0; req_addr = 17'h00007; req_data = 16'h0000;
        held_ok = 1;
        repeat (100) begin
            @(negedge clk);
            if (req_ready) held_ok = 0;
        end
        req_valid = 1'b0;
        chk(held_ok, "R11 ready low while busy", held_ok, 1);
        wait_rsp(7);
        repeat (20) @(negedge clk);
        chk(rsp_seen == 7 && wr_q.size() == 0 && rsp_q.size() == 0,
            "R11 held request not accepted", rsp_seen, 7);

        // R2, R3, R8 timing
        chk(viol_wp == 0,  "R2 write pulse width", viol_wp, 0);
        chk(viol_oe == 0,  "R2 oe high during write", viol_oe, 0);
        chk(viol_gap == 0, "R3 write pulse gap", viol_gap, 0);
        chk(viol_oeh == 0, "R8 oe high between reads", viol_oeh, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule